// File: doc/BRIEF.md
# Discrete-Time AGC Attenuation Controller

This block closes a digital automatic gain control loop around an external variable-gain amplifier. On each loop update it compares a linear signal-strength estimate with a selectable reference level. The reference sits a fixed number of decibels below the converter clip point. The block then moves a 12-bit attenuation word up or down. That word drives the amplifier through a control DAC. The loop updates once every `TICK_DIV` master clock cycles from an internal divider.

The attenuation rises when the signal is too strong and falls when it is too weak. The two directions use different step sizes. The rising step is scaled by an attack code. The falling step is scaled by the attack code minus a decay code, clamped at zero, so fading signals are tracked more slowly than overloads. A reference selector of zero switches the loop off. While the loop is off, the attenuation word follows a manually programmed value. The upper eight bits of the word are also exported as a status field.

Top module: `agc_atten_ctrl`

## Requirements
- R1: While `rstN` is low, `attnOut` is 0 and `attnMsb` is 0.
- R2: While `refSel` is 0, the loop is disabled. `attnOut` takes the value of `manAttn` on every rising clock edge, and `estIn`, `attackCode` and `decayCode` have no effect.
- R3: When `refSel` becomes non-zero, the first loop update happens on the 60th rising edge after the change. Later updates follow every 60 edges. No update happens on any other edge.
- R4: `refSel` selects a reference level in the estimator's linear scale. With the default clip value of 960, the levels are: 1 gives 678 (3 dB below clip), 2 gives 480 (6 dB), 3 gives 341 (9 dB), 4 gives 240 (12 dB) and 5 gives 172 (15 dB). Codes 6 and 7 use the 15 dB level.
- R5: On an update where `estIn` is above the reference, `attnOut` increases by step(`estIn` − ref, `attackCode`).
- R6: On an update where `estIn` is below the reference, `attnOut` decreases by step(ref − `estIn`, g), where g = `attackCode` − `decayCode`.
- R7: On an update where `estIn` equals the reference, `attnOut` is unchanged.
- R8: The step for error e and gain code g is (e >> (7 − g/2)), using integer division. When g is odd, (e >> (8 − g/2)) is added to that, which approximates a factor of √2 per code.
- R9: When `decayCode` exceeds `attackCode`, the gain code g for a decreasing step is 0.
- R10: `attnOut` saturates at 4095 when increasing and at 0 when decreasing, and never wraps.
- R11: `attnMsb` always equals bits [11:4] of `attnOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| estIn | input | 10 | Linear signal-strength estimate, unsigned |
| refSel | input | 3 | Reference level select; 0 disables the loop |
| attackCode | input | 4 | Attack gain code |
| decayCode | input | 4 | Decay code, subtracted from the attack code for decreasing steps |
| manAttn | input | 12 | Attenuation applied while the loop is disabled |
| attnOut | output | 12 | Attenuation word to the control DAC |
| attnMsb | output | 8 | Upper eight bits of the attenuation word |

## Verification
A manual load is visible on `attnOut` one rising edge after `manAttn` is applied with `refSel` at 0. An update with the loop enabled is visible exactly 60·k rising edges after `refSel` turns non-zero, with k the number of expected updates. The bench drives inputs on falling edges and loads each starting value through the disabled mode. It then counts the edges exactly before sampling on a falling edge. The cadence test samples at edge 59, where the old value must still be present, and again at edge 60, where the new value must appear.

// File: rtl/agc_pkg.sv
package agc_pkg;

  parameter int GAIN_W = 4;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic              load;     // copy manual attenuation
    logic              stepUp;   // add step on this edge
    logic              stepDown; // subtract step on this edge
    logic [GAIN_W-1:0] gainSel;  // effective gain code for the step
  } agcStrb_t;

endpackage

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int TICK_DIV = 60,
  parameter int REF_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REF_W-1:0]  refSel,
  input  logic [GAIN_W-1:0] attackCode,
  input  logic [GAIN_W-1:0] decayCode,
  input  logic              estAbove,
  input  logic              estBelow,
  output agcStrb_t          strb
);

  localparam int CNT_W = $clog2(TICK_DIV);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             loopOn;
  logic             tick;
  logic [GAIN_W-1:0] decayGain;

  assign loopOn = (refSel != '0);
  assign tick   = loopOn && (tickCnt == CNT_LAST);

  // Divider restarts whenever the loop is off
  always_ff @(posedge clk) begin
    if (!rstN || !loopOn) begin
      tickCnt <= '0;
    end else if (tickCnt == CNT_LAST) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // Attack minus decay, clamped at zero
  always_comb begin
    if (attackCode > decayCode) begin
      decayGain = attackCode - decayCode;
    end else begin
      decayGain = '0;
    end
  end

  always_comb begin
    strb.load     = !loopOn;
    strb.stepUp   = tick && estAbove;
    strb.stepDown = tick && estBelow;
    strb.gainSel  = estAbove ? attackCode : decayGain;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_LAST);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.stepUp, strb.stepDown}));

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

endmodule

// File: rtl/agc_datapath.sv
module agc_datapath
  import agc_pkg::*;
#(
  parameter int EST_W    = 10,
  parameter int ATTN_W   = 12,
  parameter int REF_W    = 3,
  parameter int CLIP_LVL = 960,
  parameter bit HALF_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EST_W-1:0]  estIn,
  input  logic [REF_W-1:0]  refSel,
  input  logic [ATTN_W-1:0] manAttn,
  input  agcStrb_t          strb,
  output logic              estAbove,
  output logic              estBelow,
  output logic [ATTN_W-1:0] attnQ
);

  localparam int STEP_W  = EST_W + 1;
  localparam int SUM_W   = ATTN_W + 2;
  localparam int SH_TOP  = ((1 << GAIN_W) - 1) >> 1;
  localparam int NUM_REF = 6;
  localparam logic [SUM_W-1:0] ATTN_MAX = SUM_W'((1 << ATTN_W) - 1);

  // dB-below-clip factors in 1/256 units: 3, 6, 9, 12, 15 dB
  function automatic int refScale(input int idx);
    case (idx)
      1:       refScale = 181;
      2:       refScale = 128;
      3:       refScale = 91;
      4:       refScale = 64;
      default: refScale = 46;
    endcase
  endfunction

  logic [EST_W-1:0] refTab [NUM_REF];

  for (genvar gi = 0; gi < NUM_REF; gi++) begin : g_ref
    if (gi == 0) begin : g_zero
      assign refTab[gi] = '0;
    end else begin : g_lvl
      assign refTab[gi] = EST_W'((CLIP_LVL * refScale(gi)) >> 8);
    end
  end

  logic [EST_W-1:0]  refLvl;
  logic [EST_W-1:0]  errMag;
  logic [2:0]        refIdx;
  logic [GAIN_W-2:0] gainHalf;
  logic [3:0]        shMain;
  logic [STEP_W-1:0] stepMain;
  logic [STEP_W-1:0] stepHalf;
  logic [STEP_W-1:0] stepAmt;
  logic [SUM_W-1:0]  sumUp;
  logic [SUM_W-1:0]  attnExt;
  logic [ATTN_W-1:0] attnNext;

  always_comb begin
    refIdx = 3'(refSel);
    if (refIdx > 3'd5) begin
      refIdx = 3'd5;
    end
  end

  assign refLvl   = refTab[refIdx];
  assign estAbove = estIn > refLvl;
  assign estBelow = estIn < refLvl;
  assign errMag   = estAbove ? (estIn - refLvl) : (refLvl - estIn);

  assign gainHalf = strb.gainSel[GAIN_W-1:1];
  assign shMain   = 4'(SH_TOP) - 4'(gainHalf);
  assign stepMain = STEP_W'(errMag >> shMain);

  if (HALF_EN) begin : g_half
    assign stepHalf = strb.gainSel[0] ? STEP_W'(errMag >> (shMain + 4'd1)) : '0;
  end else begin : g_nohalf
    assign stepHalf = '0;
  end

  assign stepAmt = stepMain + stepHalf;
  assign attnExt = SUM_W'(attnQ);
  assign sumUp   = attnExt + SUM_W'(stepAmt);

  always_comb begin
    attnNext = attnQ;
    if (strb.load) begin
      attnNext = manAttn;
    end else if (strb.stepUp) begin
      attnNext = (sumUp > ATTN_MAX) ? ATTN_MAX[ATTN_W-1:0] : sumUp[ATTN_W-1:0];
    end else if (strb.stepDown) begin
      attnNext = (SUM_W'(stepAmt) > attnExt) ? '0 : ATTN_W'(attnExt - SUM_W'(stepAmt));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attnQ <= '0;
    end else begin
      attnQ <= attnNext;
    end
  end

  // R2
  man_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> attnQ == $past(manAttn));

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.stepUp && !strb.stepDown) |=> $stable(attnQ));

  // R10
  up_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepUp |=> attnQ >= $past(attnQ));

  // R10
  down_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepDown |=> attnQ <= $past(attnQ));

endmodule

// File: rtl/agc_atten_ctrl.sv
module agc_atten_ctrl
  import agc_pkg::*;
#(
  parameter int EST_W    = 10,
  parameter int ATTN_W   = 12,
  parameter int TICK_DIV = 60,
  parameter int CLIP_LVL = 960,
  parameter int MSB_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EST_W-1:0]  estIn,
  input  logic [2:0]        refSel,
  input  logic [3:0]        attackCode,
  input  logic [3:0]        decayCode,
  input  logic [ATTN_W-1:0] manAttn,
  output logic [ATTN_W-1:0] attnOut,
  output logic [MSB_W-1:0]  attnMsb
);

  agcStrb_t strb;
  logic     estAbove;
  logic     estBelow;

  agc_ctrl #(
    .TICK_DIV(TICK_DIV),
    .REF_W   (3)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refSel    (refSel),
    .attackCode(attackCode),
    .decayCode (decayCode),
    .estAbove  (estAbove),
    .estBelow  (estBelow),
    .strb      (strb)
  );

  agc_datapath #(
    .EST_W   (EST_W),
    .ATTN_W  (ATTN_W),
    .REF_W   (3),
    .CLIP_LVL(CLIP_LVL),
    .HALF_EN (1'b1)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .estIn   (estIn),
    .refSel  (refSel),
    .manAttn (manAttn),
    .strb    (strb),
    .estAbove(estAbove),
    .estBelow(estBelow),
    .attnQ   (attnOut)
  );

  assign attnMsb = attnOut[ATTN_W-1 -: MSB_W];

endmodule

// File: tb/tb_agc_atten_ctrl.sv
module tb_agc_atten_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  estIn = '0;
  logic [2:0]  refSel = '0;
  logic [3:0]  attackCode = '0;
  logic [3:0]  decayCode = '0;
  logic [11:0] manAttn = '0;
  logic [11:0] attnOut;
  logic [7:0]  attnMsb;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  agc_atten_ctrl dut (
    .clk(clk), .rstN(rstN), .estIn(estIn), .refSel(refSel),
    .attackCode(attackCode), .decayCode(decayCode), .manAttn(manAttn),
    .attnOut(attnOut), .attnMsb(attnMsb)
  );

  // start, ref, est, attack, decay, ticks, expected, requirement tag
  typedef struct packed {
    logic [11:0] start;
    logic [2:0]  rs;
    logic [9:0]  est;
    logic [3:0]  atk;
    logic [3:0]  dcy;
    logic [3:0]  nt;
    logic [11:0] exp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{12'd1000, 3'd1, 10'd900,  4'd4,  4'd0, 4'd1, 12'd1006, 8'd5},  // R5 R8 even
    '{12'd1000, 3'd2, 10'd100,  4'd5,  4'd0, 4'd1, 12'd984,  8'd6},  // R6 R8 odd
    '{12'd2000, 3'd3, 10'd341,  4'd9,  4'd0, 4'd1, 12'd2000, 8'd7},  // R7
    '{12'd2000, 3'd4, 10'd1000, 4'd15, 4'd0, 4'd1, 12'd3140, 8'd8},  // R8 max gain
    '{12'd3000, 3'd5, 10'd0,    4'd10, 4'd3, 4'd1, 12'd2985, 8'd6},  // R6 difference
    '{12'd500,  3'd2, 10'd0,    4'd2,  4'd9, 4'd1, 12'd497,  8'd9},  // R9 clamp
    '{12'd4000, 3'd5, 10'd1023, 4'd15, 4'd0, 4'd1, 12'd4095, 8'd10}, // R10 top
    '{12'd100,  3'd1, 10'd0,    4'd15, 4'd0, 4'd1, 12'd0,    8'd10}, // R10 bottom
    '{12'd1000, 3'd7, 10'd300,  4'd6,  4'd0, 4'd1, 12'd1008, 8'd4},  // R4 code 7
    '{12'd1000, 3'd6, 10'd44,   4'd8,  4'd8, 4'd1, 12'd999,  8'd4},  // R4 code 6
    '{12'd1000, 3'd2, 10'd992,  4'd14, 4'd0, 4'd2, 12'd2024, 8'd3}   // R3 two updates
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadStart(input logic [11:0] v);
    @(negedge clk);
    refSel  = 3'd0;
    manAttn = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 attnOut", 32'(attnOut), 32'd0);
    check("R1 attnMsb", 32'(attnMsb), 32'd0);
    rstN = 1'b1;

    // R2 manual load, estimate ignored
    @(negedge clk);
    refSel = 3'd0; manAttn = 12'd1234; estIn = 10'd1023; attackCode = 4'd15;
    @(negedge clk);
    check("R2 load", 32'(attnOut), 32'd1234);
    estIn = 10'd0; decayCode = 4'd7;
    repeat (130) @(negedge clk);
    check("R2 hold", 32'(attnOut), 32'd1234);
    check("R11 msb", 32'(attnMsb), 32'(12'd1234 >> 4));

    // R3 cadence: unchanged at edge 59, updated at edge 60
    loadStart(12'd1000);
    refSel = 3'd1; estIn = 10'd900; attackCode = 4'd4; decayCode = 4'd0;
    repeat (59) @(negedge clk);
    check("R3 edge59", 32'(attnOut), 32'd1000);
    @(negedge clk);
    check("R3 edge60", 32'(attnOut), 32'd1006);
    repeat (59) @(negedge clk);
    check("R3 edge119", 32'(attnOut), 32'd1006);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      loadStart(VECS[i].start);
      refSel = VECS[i].rs; estIn = VECS[i].est;
      attackCode = VECS[i].atk; decayCode = VECS[i].dcy;
      repeat (60 * int'(VECS[i].nt)) @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].tag, i), 32'(attnOut), 32'(VECS[i].exp));
      check($sformatf("R11 vec%0d", i), 32'(attnMsb), 32'(VECS[i].exp >> 4));
    end

    // R2 leaving the loop restores manual value
    @(negedge clk);
    refSel = 3'd0; manAttn = 12'd77;
    @(negedge clk);
    check("R2 disable", 32'(attnOut), 32'd77);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule